// File: doc/BRIEF.md
# Ethernet Controller Command and Status Register Unit

This block is the host-facing register file that sits between a host bus and the command and receive engines of an Ethernet controller. The host reads one combined dword at offset 0. Its low half is the status word, which reports the engine states and the latched event bits. Its high half is the command word, which carries two opcode fields, an interrupt mask bit and a software-interrupt trigger. A general pointer register at offset 4 supplies the address operand for commands. A port register at offset 8 passes a dword straight to the controller together with a one-cycle strobe.

The engines sit outside this block. A pending opcode stays visible to its engine until that engine pulses its accept input. The field then clears itself, so the host waits for both opcode fields to read zero before it issues the next command. When a start or resume opcode is accepted, the pointer value is copied into that engine's own pointer output in the same cycle. The engines report events with one-cycle pulses. Each pulse latches a status bit until the host acknowledges it by writing a one to it. The interrupt output is raised whenever a latched event is present and the mask bit is clear.

Top module: `nic_csr_unit`

## Requirements
- R1: After reset, every event bit, both opcode fields, the mask bit, the pointer and port registers, `irq` and `portStrobe` are all zero.
- R2: An event pulse sets a status bit in the cycle after the pulse, and the bit holds until it is acknowledged. The mapping is `evtPulse[0]`→bit 15 (command done), `[1]`→14 (frame received), `[2]`→13 (command unit left active), `[3]`→12 (receiver left ready), `[4]`→11 (management cycle done), `[5]`→8 (flow-control pause). Bit 10 is the software interrupt.
- R3: A write to offset 0 with byte lane 1 enabled clears each event bit whose data bit is one, under mask 0xFD00. A zero data bit leaves the event bit unchanged. Status bits 9 and 7:0 cannot be written.
- R4: When an event pulse and an acknowledge of the same bit fall in the same cycle, the bit ends up set.
- R5: Lane 2 of offset 0 writes the command-unit opcode from bus bits 23:20 (command bits 7:4). The opcode stays on `cuCmd` until `cuAccept` is pulsed, and it reads zero in the following cycle.
- R6: Lane 2 of offset 0 also writes the receive-unit opcode from bus bits 18:16 (command bits 2:0). It is held and cleared by `ruAccept` in the same way, and it does not depend on the command-unit field.
- R7: Accepting command-unit opcode 1 (start) or 2 (resume) copies the pointer register into `cuPtr`. Accepting receive-unit opcode 1 or 2 copies it into `ruPtr`. No other opcode changes these outputs.
- R8: Bus bit 24 (command bit 8), written through lane 3, is the mask bit. `irq` is high exactly when some event bit is set and the mask bit is zero.
- R9: Writing a one to bus bit 25 (command bit 9) through lane 3 sets event bit 10. Bit 25 always reads back as zero.
- R10: Status bits 7:6 show `cuState`, bits 4:2 show `ruState`, and bit 5 shows the no-buffers qualifier `ruNoBuf`.
- R11: The pointer at offset 4 is written byte by byte under the lane enables. A write to offset 8 loads all 32 bits of the port register and pulses `portStrobe` for exactly one cycle. Unmapped offsets read zero.
- R12: If an opcode write and an accept fall in the same cycle, the newly written opcode is the one that remains pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Host write strobe |
| busAddr | input | ADDR_W | Byte address of the register |
| busByteEn | input | 4 | Byte lane enables |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Combinational read data |
| evtPulse | input | 6 | Event pulses from the engines |
| cuAccept | input | 1 | Command engine takes the pending opcode |
| ruAccept | input | 1 | Receive engine takes the pending opcode |
| cuState | input | 2 | Command engine state code |
| ruState | input | 3 | Receive engine state code |
| ruNoBuf | input | 1 | Receive engine is out of buffer descriptors |
| cuCmd | output | 4 | Pending command-unit opcode |
| ruCmd | output | 3 | Pending receive-unit opcode |
| cuPtr | output | 32 | Pointer captured for the command engine |
| ruPtr | output | 32 | Pointer captured for the receive engine |
| portWord | output | 32 | Port register contents |
| portStrobe | output | 1 | One-cycle pulse after a port write |
| irq | output | 1 | Interrupt request |

## Verification
The main function, event latching with acknowledge and interrupt gating, is driven by a table of vectors. The table covers a single event, two simultaneous events, an acknowledge of one set bit beside others that stay set, a write to the unmaskable bit 9, and an event pulse that collides with its own acknowledge. That set separates a correct write-one-to-clear from a plain overwrite and from an acknowledge that wrongly wins. Masking and unmasking with events pending show whether `irq` follows the mask bit or the events. The opcode tests apply each accept to both engines alone and together, and use capturing and non-capturing opcodes with different pointer values. The pointer outputs can therefore only match if the capture is both qualified by opcode and steered to the correct engine.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;

  localparam int NUM_EXT_EVT = 6;
  localparam int NUM_EVT     = NUM_EXT_EVT + 1;  // plus software interrupt
  localparam logic [15:0] ACK_MASK = 16'hFD00;

  localparam logic [3:0] CU_OP_START  = 4'd1;
  localparam logic [3:0] CU_OP_RESUME = 4'd2;
  localparam logic [2:0] RU_OP_START  = 3'd1;
  localparam logic [2:0] RU_OP_RESUME = 3'd2;

  typedef struct packed {
    logic       wrAck;
    logic       wrCmdLo;
    logic       wrCmdHi;
    logic [3:0] wrPtrBe;
    logic       wrPort;
  } csrStrobes_t;

  // Status bit position of each latched event; index 6 is the software interrupt.
  function automatic int evtBitPos(input int idx);
    case (idx)
      0:       return 15;
      1:       return 14;
      2:       return 13;
      3:       return 12;
      4:       return 11;
      5:       return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/nic_csr_ctrl.sv
module nic_csr_ctrl
  import nic_csr_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busByteEn,
  input  logic [15:0]       statusWord,
  input  logic [15:0]       cmdWord,
  input  logic [31:0]       ptrWord,
  input  logic [31:0]       portWord,
  output csrStrobes_t       strb,
  output logic [31:0]       busRData
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] IDX_SCB  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_PTR  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_PORT = IDX_W'(2);

  logic [IDX_W-1:0] dwIdx;
  assign dwIdx = busAddr[ADDR_W-1:2];

  always_comb begin
    strb         = '0;
    strb.wrAck   = busWr && (dwIdx == IDX_SCB) && busByteEn[1];
    strb.wrCmdLo = busWr && (dwIdx == IDX_SCB) && busByteEn[2];
    strb.wrCmdHi = busWr && (dwIdx == IDX_SCB) && busByteEn[3];
    strb.wrPtrBe = (busWr && (dwIdx == IDX_PTR)) ? busByteEn : 4'b0000;
    strb.wrPort  = busWr && (dwIdx == IDX_PORT) && (|busByteEn);
  end

  always_comb begin
    case (dwIdx)
      IDX_SCB:  busRData = {cmdWord, statusWord};
      IDX_PTR:  busRData = ptrWord;
      IDX_PORT: busRData = portWord;
      default:  busRData = '0;
    endcase
  end

endmodule

// File: rtl/nic_csr_regs.sv
module nic_csr_regs
  import nic_csr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  csrStrobes_t            strb,
  input  logic [31:0]            wData,
  input  logic [NUM_EXT_EVT-1:0] evtPulse,
  input  logic                   cuAccept,
  input  logic                   ruAccept,
  input  logic [1:0]             cuState,
  input  logic [2:0]             ruState,
  input  logic                   ruNoBuf,
  output logic [15:0]            statusWord,
  output logic [15:0]            cmdWord,
  output logic [31:0]            ptrWord,
  output logic [31:0]            portWord,
  output logic                   portStrobe,
  output logic [3:0]             cuCmd,
  output logic [2:0]             ruCmd,
  output logic [31:0]            cuPtr,
  output logic [31:0]            ruPtr,
  output logic                   irq
);
  logic [NUM_EVT-1:0] evt;
  logic [NUM_EVT-1:0] evtSet;
  logic               maskBit;
  logic               swiReq;
  logic               cuCapture;
  logic               ruCapture;

  assign swiReq = strb.wrCmdHi && wData[25];
  assign evtSet = {swiReq, evtPulse};

  // Event latches: a new event takes priority over its acknowledge.
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    localparam int POS = evtBitPos(i);
    logic ackHit;
    assign ackHit = strb.wrAck && wData[POS] && ACK_MASK[POS];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          evt[i] <= 1'b0;
      else if (evtSet[i]) evt[i] <= 1'b1;
      else if (ackHit)    evt[i] <= 1'b0;
    end

    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      evtSet[i] |=> evt[i]);
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (evt[i] && !ackHit) |=> evt[i]);
  end

  always_comb begin
    statusWord = '0;
    for (int i = 0; i < NUM_EVT; i++) statusWord[evtBitPos(i)] = evt[i];
    statusWord[7:6] = cuState;
    statusWord[5]   = ruNoBuf;
    statusWord[4:2] = ruState;
  end

  // Opcode fields: a fresh write wins over an acceptance in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cuCmd   <= '0;
      ruCmd   <= '0;
      maskBit <= 1'b0;
    end else begin
      if (strb.wrCmdLo)  cuCmd <= wData[23:20];
      else if (cuAccept) cuCmd <= '0;
      if (strb.wrCmdLo)  ruCmd <= wData[18:16];
      else if (ruAccept) ruCmd <= '0;
      if (strb.wrCmdHi)  maskBit <= wData[24];
    end
  end

  assign cmdWord = {6'b0, 1'b0, maskBit, cuCmd, 1'b0, ruCmd};

  assign cuCapture = cuAccept && (cuCmd == CU_OP_START || cuCmd == CU_OP_RESUME);
  assign ruCapture = ruAccept && (ruCmd == RU_OP_START || ruCmd == RU_OP_RESUME);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cuPtr <= '0;
      ruPtr <= '0;
    end else begin
      if (cuCapture) cuPtr <= ptrWord;
      if (ruCapture) ruPtr <= ptrWord;
    end
  end

  for (genvar b = 0; b < 4; b++) begin : g_ptr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                ptrWord[8*b +: 8] <= '0;
      else if (strb.wrPtrBe[b]) ptrWord[8*b +: 8] <= wData[8*b +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portWord   <= '0;
      portStrobe <= 1'b0;
    end else begin
      portStrobe <= strb.wrPort;
      if (strb.wrPort) portWord <= wData;
    end
  end

  assign irq = (|evt) && !maskBit;

  a_r5_cu_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cuCmd != '0 && !cuAccept && !strb.wrCmdLo) |=> $stable(cuCmd));
  a_r5_cu_clear: assert property (@(posedge clk) disable iff (!rstN)
    (cuAccept && !strb.wrCmdLo) |=> (cuCmd == '0));
  a_r6_ru_clear: assert property (@(posedge clk) disable iff (!rstN)
    (ruAccept && !strb.wrCmdLo) |=> (ruCmd == '0));
  a_r7_cu_capture: assert property (@(posedge clk) disable iff (!rstN)
    cuCapture |=> (cuPtr == $past(ptrWord)));
  a_r7_ru_keep: assert property (@(posedge clk) disable iff (!rstN)
    !ruCapture |=> $stable(ruPtr));
  a_r8_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((statusWord & ACK_MASK) != 16'h0));
  a_r11_port_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrPort |=> !portStrobe);

endmodule

// File: rtl/nic_csr_unit.sv
module nic_csr_unit
  import nic_csr_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busWr,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [3:0]             busByteEn,
  input  logic [31:0]            busWData,
  output logic [31:0]            busRData,
  input  logic [NUM_EXT_EVT-1:0] evtPulse,
  input  logic                   cuAccept,
  input  logic                   ruAccept,
  input  logic [1:0]             cuState,
  input  logic [2:0]             ruState,
  input  logic                   ruNoBuf,
  output logic [3:0]             cuCmd,
  output logic [2:0]             ruCmd,
  output logic [31:0]            cuPtr,
  output logic [31:0]            ruPtr,
  output logic [31:0]            portWord,
  output logic                   portStrobe,
  output logic                   irq
);
  csrStrobes_t strb;
  logic [15:0] statusWord;
  logic [15:0] cmdWord;
  logic [31:0] ptrWord;

  nic_csr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busWr      (busWr),
    .busAddr    (busAddr),
    .busByteEn  (busByteEn),
    .statusWord (statusWord),
    .cmdWord    (cmdWord),
    .ptrWord    (ptrWord),
    .portWord   (portWord),
    .strb       (strb),
    .busRData   (busRData)
  );

  nic_csr_regs u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wData      (busWData),
    .evtPulse   (evtPulse),
    .cuAccept   (cuAccept),
    .ruAccept   (ruAccept),
    .cuState    (cuState),
    .ruState    (ruState),
    .ruNoBuf    (ruNoBuf),
    .statusWord (statusWord),
    .cmdWord    (cmdWord),
    .ptrWord    (ptrWord),
    .portWord   (portWord),
    .portStrobe (portStrobe),
    .cuCmd      (cuCmd),
    .ruCmd      (ruCmd),
    .cuPtr      (cuPtr),
    .ruPtr      (ruPtr),
    .irq        (irq)
  );

endmodule

// File: tb/tb_nic_csr_unit.sv
module tb_nic_csr_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [3:0]  busByteEn = '0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic [5:0]  evtPulse = '0;
  logic        cuAccept = 1'b0;
  logic        ruAccept = 1'b0;
  logic [1:0]  cuState = '0;
  logic [2:0]  ruState = '0;
  logic        ruNoBuf = 1'b0;
  logic [3:0]  cuCmd;
  logic [2:0]  ruCmd;
  logic [31:0] cuPtr, ruPtr, portWord;
  logic        portStrobe, irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  nic_csr_unit dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busByteEn(busByteEn), .busWData(busWData), .busRData(busRData),
    .evtPulse(evtPulse), .cuAccept(cuAccept), .ruAccept(ruAccept),
    .cuState(cuState), .ruState(ruState), .ruNoBuf(ruNoBuf),
    .cuCmd(cuCmd), .ruCmd(ruCmd), .cuPtr(cuPtr), .ruPtr(ruPtr),
    .portWord(portWord), .portStrobe(portStrobe), .irq(irq)
  );

  typedef struct packed {
    logic [5:0]  evt;
    logic        wr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [31:0] exp;
    logic        expIrq;
  } vec_t;

  // All table writes go to offset 0.
  localparam vec_t VECS [12] = '{
    '{6'b000010, 1'b0, 4'b0000, 32'h0000_0000, 32'h0000_4000, 1'b1},
    '{6'b100001, 1'b0, 4'b0000, 32'h0000_0000, 32'h0000_C100, 1'b1},
    '{6'b000000, 1'b1, 4'b0010, 32'h0000_4000, 32'h0000_8100, 1'b1},
    '{6'b000000, 1'b1, 4'b0010, 32'h0000_0200, 32'h0000_8100, 1'b1},
    '{6'b000000, 1'b1, 4'b1000, 32'h0100_0000, 32'h0100_8100, 1'b0},
    '{6'b000100, 1'b1, 4'b0010, 32'h0000_8000, 32'h0100_2100, 1'b0},
    '{6'b001000, 1'b1, 4'b0010, 32'h0000_1000, 32'h0100_3100, 1'b0},
    '{6'b000000, 1'b1, 4'b1000, 32'h0000_0000, 32'h0000_3100, 1'b1},
    '{6'b000000, 1'b1, 4'b0010, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
    '{6'b000000, 1'b1, 4'b1000, 32'h0200_0000, 32'h0000_0400, 1'b1},
    '{6'b010000, 1'b0, 4'b0000, 32'h0000_0000, 32'h0000_0C00, 1'b1},
    '{6'b000000, 1'b1, 4'b0010, 32'h0000_FD00, 32'h0000_0000, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRData;
  endtask

  task automatic wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busByteEn = be; busWData = d;
    @(negedge clk);
    busWr = 1'b0; busByteEn = '0;
  endtask

  task automatic pulseAccept(input logic cu, input logic ru);
    @(negedge clk);
    cuAccept = cu; ruAccept = ru;
    @(negedge clk);
    cuAccept = 1'b0; ruAccept = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'd0, d); chk("R1 scb dword", d, 32'h0);
    rd(5'd4, d); chk("R1 pointer", d, 32'h0);
    rd(5'd8, d); chk("R1 port", d, 32'h0);
    chk("R1 irq/strobe/cmds", {irq, portStrobe, cuCmd, ruCmd}, 32'h0);

    // Table: events, acknowledge, mask, software interrupt (R2 R3 R4 R8 R9)
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      evtPulse = VECS[i].evt;
      busWr = VECS[i].wr; busAddr = 5'd0; busByteEn = VECS[i].be; busWData = VECS[i].data;
      @(negedge clk);
      evtPulse = '0; busWr = 1'b0; busByteEn = '0;
      rd(5'd0, d);
      chk($sformatf("R2/R3/R4/R9 vec%0d status", i), d, VECS[i].exp);
      chk($sformatf("R8 vec%0d irq", i), {31'b0, irq}, {31'b0, VECS[i].expIrq});
    end

    // R11 pointer byte lanes, port strobe, unmapped offset
    wr(5'd4, 4'b1111, 32'h1234_5678);
    rd(5'd4, d); chk("R11 pointer full", d, 32'h1234_5678);
    wr(5'd4, 4'b0001, 32'hFFFF_FFFF);
    rd(5'd4, d); chk("R11 pointer lane0", d, 32'h1234_56FF);
    wr(5'd8, 4'b1111, 32'hA5A5_0003);
    chk("R11 port strobe high", {31'b0, portStrobe}, 32'h1);
    chk("R11 port word", portWord, 32'hA5A5_0003);
    @(negedge clk);
    chk("R11 port strobe one cycle", {31'b0, portStrobe}, 32'h0);
    rd(5'd12, d); chk("R11 unmapped", d, 32'h0);

    // R5 command-unit opcode held then cleared, R7 start captures
    wr(5'd0, 4'b0100, 32'h0010_0000);
    rd(5'd0, d); chk("R5 readback", d, 32'h0010_0000);
    repeat (3) @(negedge clk);
    chk("R5 held", {28'b0, cuCmd}, 32'd1);
    pulseAccept(1'b1, 1'b0);
    chk("R5 cleared", {28'b0, cuCmd}, 32'd0);
    chk("R7 cu start capture", cuPtr, 32'h1234_56FF);

    // R6 both pending, independent accept
    wr(5'd0, 4'b0100, 32'h0041_0000);
    pulseAccept(1'b0, 1'b1);
    chk("R6 ru cleared, cu kept", {25'b0, cuCmd, ruCmd}, {25'b0, 4'd4, 3'd0});
    chk("R7 ru start capture", ruPtr, 32'h1234_56FF);
    wr(5'd4, 4'b1111, 32'h0BAD_F00D);
    pulseAccept(1'b1, 1'b0);
    chk("R6 cu cleared", {28'b0, cuCmd}, 32'd0);
    chk("R7 cu stats no capture", cuPtr, 32'h1234_56FF);

    // R7 receive resume captures, resume-no-resources does not
    wr(5'd0, 4'b0100, 32'h0002_0000);
    pulseAccept(1'b0, 1'b1);
    chk("R7 ru resume capture", ruPtr, 32'h0BAD_F00D);
    wr(5'd4, 4'b1111, 32'hCAFE_0000);
    wr(5'd0, 4'b0100, 32'h0007_0000);
    pulseAccept(1'b0, 1'b1);
    chk("R7 ru code7 no capture", ruPtr, 32'h0BAD_F00D);
    chk("R6 ru code7 cleared", {29'b0, ruCmd}, 32'd0);

    // R12 write and accept in the same cycle
    wr(5'd0, 4'b0100, 32'h0050_0000);
    @(negedge clk);
    busWr = 1'b1; busAddr = 5'd0; busByteEn = 4'b0100; busWData = 32'h0020_0000; cuAccept = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busByteEn = '0; cuAccept = 1'b0;
    chk("R12 new opcode wins", {28'b0, cuCmd}, 32'd2);
    chk("R12 dump not captured", cuPtr, 32'h1234_56FF);
    pulseAccept(1'b1, 1'b0);
    chk("R7 cu resume capture", cuPtr, 32'hCAFE_0000);

    // R10 engine state fields, not writable (R3)
    @(negedge clk);
    cuState = 2'd2; ruState = 3'd4; ruNoBuf = 1'b1;
    rd(5'd0, d); chk("R10 states ready+nobuf", d, 32'h0000_00B0);
    wr(5'd0, 4'b0011, 32'h0000_FFFF);
    rd(5'd0, d); chk("R3 state bits unwritable", d, 32'h0000_00B0);
    cuState = 2'd1; ruState = 3'd1; ruNoBuf = 1'b0;
    rd(5'd0, d); chk("R10 states suspended", d, 32'h0000_0044);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule